// File: doc/BRIEF.md
# Dispatch Slot Budget Controller

This block decides, beat by beat, whether the instruction offered by an out-of-order front end may enter the dispatch stage. A dispatch cycle is opened by a `cycle_start` pulse, and the block then holds a budget of free dispatch slots for that cycle. Within the cycle the front end offers at most one candidate per clock. Each candidate carries its micro-op count and two grouping flags: begin-group and end-group. Acceptance is decided combinationally in the same beat. It depends on the remaining budget, the grouping rules, and three readiness inputs: free reorder-buffer entries, register-file write acceptance and the next stage's ready. Nothing is buffered inside the block.

An instruction with more micro-ops than the dispatch width takes the whole budget of its cycle. The micro-ops beyond the width become a carry-over. This carry-over is drained from the budgets of the cycles that follow, and no new instruction is admitted until it reaches zero. The block reports how many micro-ops went out in each beat. That count includes drained carry-over and a freshly accepted instruction. The block also flags which resource refused a candidate that otherwise had room.

Top module: `dispatch_budget`

## Requirements
- R1: A synchronous active-high `rst` clears the carry-over and sets `slots_free` to the dispatch width W; `carry_pending`, `accept` and `disp_count` read 0 with no candidate.
- R2: On a `cycle_start` beat with no carry-over, `slots_free` shows the full width W.
- R3: A candidate needs min(`in_uops`, W) free slots. With fewer it is refused, and the budget remains unchanged for the next beat. An accepted candidate of k ≤ W micro-ops lowers `slots_free` by k in the following beat.
- R4: A candidate with `in_begin_grp`=1 is accepted only when `slots_free` equals W.
- R5: After a candidate with `in_end_grp`=1 is accepted, `slots_free` reads 0 until the next `cycle_start`.
- R6: An accepted candidate with `in_uops` > W consumes all W slots, reports `disp_count`=W, and leaves a carry-over of `in_uops`−W.
- R7: On a `cycle_start` beat with carry-over c, `slots_free` is 0 if c ≥ W and W−c otherwise. The drained amount W−`slots_free` is reported in `disp_count`, and c is reduced by that amount.
- R8: While carry-over remains after the drain of the current beat, `carry_pending`=1 and `accept`=0.
- R9: Acceptance also requires `rob_free` ≥ `in_uops`, `rf_ready`=1 and `next_ready`=1, all in the same beat.
- R10: A candidate that passes the slot and grouping checks raises `stall_rob` when `rob_free` < `in_uops` and raises `stall_rf` when `rf_ready`=0. Both may be raised together. Neither is raised when the slot checks fail.
- R11: A configured width `CFG_WIDTH` of 0 selects `DEFAULT_WIDTH` as W.
- R12: When drained carry-over and a fresh accept fall in the same beat, `disp_count` is their sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_start | input | 1 | Opens a new dispatch cycle in this beat |
| in_valid | input | 1 | A candidate instruction is offered |
| in_uops | input | UOP_W | Micro-op count of the candidate |
| in_begin_grp | input | 1 | Candidate must open a dispatch group |
| in_end_grp | input | 1 | Candidate closes the dispatch group |
| rob_free | input | ROB_W | Free reorder-buffer entries |
| rf_ready | input | 1 | Register file can take all destination writes |
| next_ready | input | 1 | Next stage can take the instruction |
| accept | output | 1 | Candidate dispatched in this beat |
| disp_count | output | CNT_W | Micro-ops dispatched in this beat |
| slots_free | output | SLOT_W | Slot budget seen by this beat's candidate |
| carry_pending | output | 1 | Carry-over remains after this beat's drain |
| stall_rob | output | 1 | Refused for lack of reorder-buffer room |
| stall_rf | output | 1 | Refused by the register file |

## Verification
The drain of a carry-over and the admission of a new instruction can both happen in one beat. This occurs when a `cycle_start` empties the last of the carry-over and leaves slots, and a candidate is already waiting. The bench sets this up with a ten-micro-op instruction on a width of four. It then waits out two cycle starts and checks that the second one reports the two drained micro-ops plus the two of the new instruction, and that it leaves no slots behind. The two stall flags also fall in one beat, and a separate check raises both together.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    // Reasons a candidate with enough slots was turned away.
    typedef struct packed {
        logic rob_short;
        logic rf_busy;
    } stall_t;

endpackage

// File: rtl/dsb_refill.sv
// Budget for a freshly opened dispatch cycle, after draining carry-over.
module dsb_refill #(
    parameter int W      = 4,
    parameter int UOP_W  = 6,
    parameter int SLOT_W = 3
) (
    input  logic [UOP_W-1:0]  carry_q,
    output logic [SLOT_W-1:0] fresh_avail,
    output logic [SLOT_W-1:0] drained,
    output logic [UOP_W-1:0]  carry_left
);

    localparam logic [UOP_W-1:0]  W_U = UOP_W'(W);
    localparam logic [SLOT_W-1:0] W_S = SLOT_W'(W);

    always_comb begin
        if (carry_q == '0) begin
            fresh_avail = W_S;
            drained     = '0;
        end else if (carry_q >= W_U) begin
            fresh_avail = '0;
            drained     = W_S;
        end else begin
            fresh_avail = W_S - SLOT_W'(carry_q);
            drained     = SLOT_W'(carry_q);
        end
        carry_left = carry_q - UOP_W'(drained);
    end

endmodule

// File: rtl/dsb_admit.sv
// Same-beat admission decision and stall reasons.
module dsb_admit
    import dsb_pkg::*;
#(
    parameter int W      = 4,
    parameter int UOP_W  = 6,
    parameter int SLOT_W = 3,
    parameter int ROB_W  = 7
) (
    input  logic              valid,
    input  logic [UOP_W-1:0]  uops,
    input  logic              begin_grp,
    input  logic [SLOT_W-1:0] avail,
    input  logic              carry_busy,
    input  logic [ROB_W-1:0]  rob_free,
    input  logic              rf_ready,
    input  logic              next_ready,
    output logic [SLOT_W-1:0] need,
    output logic              accept,
    output stall_t            stall
);

    localparam int CMP_W = (UOP_W > ROB_W) ? UOP_W : ROB_W;
    localparam logic [UOP_W-1:0]  W_U = UOP_W'(W);
    localparam logic [SLOT_W-1:0] W_S = SLOT_W'(W);

    logic slot_ok;
    logic group_ok;
    logic rob_room;

    always_comb begin
        need     = (uops > W_U) ? W_S : SLOT_W'(uops);
        group_ok = !begin_grp || (avail == W_S);
        slot_ok  = valid && !carry_busy && (need <= avail) && group_ok;
        rob_room = CMP_W'(rob_free) >= CMP_W'(uops);
        stall.rob_short = slot_ok && !rob_room;
        stall.rf_busy   = slot_ok && !rf_ready;
        accept   = slot_ok && rob_room && rf_ready && next_ready;
    end

endmodule

// File: rtl/dispatch_budget.sv
module dispatch_budget
    import dsb_pkg::*;
#(
    parameter int CFG_WIDTH     = 4,
    parameter int DEFAULT_WIDTH = 4,
    parameter int UOP_W         = 6,
    parameter int ROB_W         = 7,
    localparam int W            = (CFG_WIDTH == 0) ? DEFAULT_WIDTH : CFG_WIDTH,
    localparam int SLOT_W       = $clog2(W + 1),
    localparam int CNT_W        = $clog2(2 * W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cycle_start,
    input  logic              in_valid,
    input  logic [UOP_W-1:0]  in_uops,
    input  logic              in_begin_grp,
    input  logic              in_end_grp,
    input  logic [ROB_W-1:0]  rob_free,
    input  logic              rf_ready,
    input  logic              next_ready,
    output logic              accept,
    output logic [CNT_W-1:0]  disp_count,
    output logic [SLOT_W-1:0] slots_free,
    output logic              carry_pending,
    output logic              stall_rob,
    output logic              stall_rf
);

    localparam logic [UOP_W-1:0]  W_U = UOP_W'(W);
    localparam logic [SLOT_W-1:0] W_S = SLOT_W'(W);

    typedef struct packed {
        logic [SLOT_W-1:0] avail;
        logic [UOP_W-1:0]  carry;
    } state_t;

    state_t st_d, st_q;

    logic [SLOT_W-1:0] fresh_avail, drained, need;
    logic [UOP_W-1:0]  carry_left;
    logic [SLOT_W-1:0] avail_eff;
    logic [UOP_W-1:0]  carry_eff;
    logic              acc;
    stall_t            stall;

    dsb_refill #(.W(W), .UOP_W(UOP_W), .SLOT_W(SLOT_W)) u_refill (
        .carry_q     (st_q.carry),
        .fresh_avail (fresh_avail),
        .drained     (drained),
        .carry_left  (carry_left)
    );

    always_comb begin
        avail_eff = cycle_start ? fresh_avail : st_q.avail;
        carry_eff = cycle_start ? carry_left  : st_q.carry;
    end

    dsb_admit #(.W(W), .UOP_W(UOP_W), .SLOT_W(SLOT_W), .ROB_W(ROB_W)) u_admit (
        .valid      (in_valid),
        .uops       (in_uops),
        .begin_grp  (in_begin_grp),
        .avail      (avail_eff),
        .carry_busy (carry_eff != '0),
        .rob_free   (rob_free),
        .rf_ready   (rf_ready),
        .next_ready (next_ready),
        .need       (need),
        .accept     (acc),
        .stall      (stall)
    );

    always_comb begin
        st_d.avail = avail_eff;
        st_d.carry = carry_eff;
        if (acc) begin
            if (in_uops > W_U) begin
                st_d.avail = '0;
                st_d.carry = in_uops - W_U;
            end else begin
                st_d.avail = avail_eff - need;
            end
            if (in_end_grp) begin
                st_d.avail = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.avail <= W_S;
            st_q.carry <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        accept        = acc;
        slots_free    = avail_eff;
        carry_pending = carry_eff != '0;
        stall_rob     = stall.rob_short;
        stall_rf      = stall.rf_busy;
        disp_count    = (cycle_start ? CNT_W'(drained) : '0)
                      + (acc ? CNT_W'(need) : '0);
    end

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker #(
    parameter int W      = 4,
    parameter int UOP_W  = 6,
    parameter int SLOT_W = 3,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cycle_start,
    input logic              in_valid,
    input logic [UOP_W-1:0]  in_uops,
    input logic              in_begin_grp,
    input logic              in_end_grp,
    input logic              rf_ready,
    input logic              next_ready,
    input logic              accept,
    input logic [CNT_W-1:0]  disp_count,
    input logic [SLOT_W-1:0] slots_free,
    input logic              carry_pending,
    input logic              stall_rob,
    input logic              stall_rf
);

    logic [UOP_W:0] need_chk;
    assign need_chk = (in_uops > UOP_W'(W)) ? (UOP_W+1)'(W) : {1'b0, in_uops};

    a_r9_ready_gate: assert property (@(posedge clk) disable iff (rst)
        accept |-> (next_ready && rf_ready && in_valid));

    a_r8_carry_blocks: assert property (@(posedge clk) disable iff (rst)
        carry_pending |-> !accept);

    a_r4_begin_full: assert property (@(posedge clk) disable iff (rst)
        (accept && in_begin_grp) |-> (slots_free == SLOT_W'(W)));

    a_r5_end_closes: assert property (@(posedge clk) disable iff (rst)
        (accept && in_end_grp) |=> (cycle_start || slots_free == '0));

    a_r3_fits: assert property (@(posedge clk) disable iff (rst)
        accept |-> (need_chk <= (UOP_W+1)'(slots_free)));

    a_r10_stall_refuses: assert property (@(posedge clk) disable iff (rst)
        (stall_rob || stall_rf) |-> !accept);

    a_r12_count_bound: assert property (@(posedge clk) disable iff (rst)
        (!cycle_start && !accept) |-> (disp_count == '0));

endmodule

bind dispatch_budget dsb_checker #(
    .W(W), .UOP_W(UOP_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .cycle_start(cycle_start), .in_valid(in_valid),
    .in_uops(in_uops), .in_begin_grp(in_begin_grp), .in_end_grp(in_end_grp),
    .rf_ready(rf_ready), .next_ready(next_ready), .accept(accept),
    .disp_count(disp_count), .slots_free(slots_free),
    .carry_pending(carry_pending), .stall_rob(stall_rob), .stall_rf(stall_rf)
);

// File: tb/dispatch_budget_test.sv
module dispatch_budget_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cycle_start, in_valid, in_begin_grp, in_end_grp;
    logic [5:0] in_uops;
    logic [6:0] rob_free;
    logic       rf_ready, next_ready;

    logic       accept, carry_pending, stall_rob, stall_rf;
    logic [3:0] disp_count;
    logic [2:0] slots_free;

    logic       d_accept, d_carry, d_srob, d_srf;
    logic [2:0] d_count;
    logic [1:0] d_slots;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispatch_budget uut (
        .clk(clk), .rst(rst), .cycle_start(cycle_start), .in_valid(in_valid),
        .in_uops(in_uops), .in_begin_grp(in_begin_grp), .in_end_grp(in_end_grp),
        .rob_free(rob_free), .rf_ready(rf_ready), .next_ready(next_ready),
        .accept(accept), .disp_count(disp_count), .slots_free(slots_free),
        .carry_pending(carry_pending), .stall_rob(stall_rob), .stall_rf(stall_rf)
    );

    dispatch_budget #(.CFG_WIDTH(0), .DEFAULT_WIDTH(3)) uut_dflt (
        .clk(clk), .rst(rst), .cycle_start(cycle_start), .in_valid(in_valid),
        .in_uops(in_uops), .in_begin_grp(in_begin_grp), .in_end_grp(in_end_grp),
        .rob_free(rob_free), .rf_ready(rf_ready), .next_ready(next_ready),
        .accept(d_accept), .disp_count(d_count), .slots_free(d_slots),
        .carry_pending(d_carry), .stall_rob(d_srob), .stall_rf(d_srf)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one beat at the falling edge; outputs are sampled 1 time unit later.
    task automatic beat(bit cs, bit v, int u, bit b, bit e, int rob, bit rf, bit nx);
        @(negedge clk);
        cycle_start  = cs;
        in_valid     = v;
        in_uops      = 6'(u);
        in_begin_grp = b;
        in_end_grp   = e;
        rob_free     = 7'(rob);
        rf_ready     = rf;
        next_ready   = nx;
        #1;
    endtask

    task automatic idle();
        beat(1'b1, 1'b0, 0, 1'b0, 1'b0, 64, 1'b1, 1'b1);
    endtask

    task automatic t_reset();
        beat(1'b0, 1'b0, 0, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R1 slots", slots_free, 4);
        check("R1 carry", carry_pending, 0);
        check("R1 accept", accept, 0);
        check("R1 count", disp_count, 0);
    endtask

    task automatic t_default_width();
        beat(1'b1, 1'b1, 5, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R11 slots", d_slots, 3);
        check("R11 accept", d_accept, 1);
        check("R11 count", d_count, 3);
        beat(1'b1, 1'b0, 0, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R11 drain", d_count, 2);
        check("R11 slots after drain", d_slots, 1);
    endtask

    task automatic t_fill();
        beat(1'b1, 1'b1, 2, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R2 fresh", slots_free, 4);
        check("R3 accept", accept, 1);
        check("R3 count", disp_count, 2);
        beat(1'b0, 1'b1, 3, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R3 slots", slots_free, 2);
        check("R3 refuse", accept, 0);
        check("R10 no stall on slot refusal", stall_rob + stall_rf, 0);
        beat(1'b0, 1'b1, 2, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R3 unchanged", slots_free, 2);
        check("R3 accept exact", accept, 1);
        beat(1'b0, 1'b0, 0, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R3 empty", slots_free, 0);
    endtask

    task automatic t_begin();
        beat(1'b1, 1'b1, 1, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R3 accept one", accept, 1);
        beat(1'b0, 1'b1, 1, 1'b1, 1'b0, 64, 1'b1, 1'b1);
        check("R4 refuse partial", accept, 0);
        beat(1'b1, 1'b1, 1, 1'b1, 1'b0, 64, 1'b1, 1'b1);
        check("R4 accept full", accept, 1);
    endtask

    task automatic t_end();
        beat(1'b1, 1'b1, 1, 1'b0, 1'b1, 64, 1'b1, 1'b1);
        check("R5 accept", accept, 1);
        beat(1'b0, 1'b1, 1, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R5 closed", slots_free, 0);
        check("R5 refuse", accept, 0);
        beat(1'b1, 1'b0, 0, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R2 reopened", slots_free, 4);
    endtask

    task automatic t_oversize();
        beat(1'b1, 1'b1, 10, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R6 accept", accept, 1);
        check("R6 count", disp_count, 4);
        beat(1'b0, 1'b1, 1, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R8 pending", carry_pending, 1);
        check("R8 blocked", accept, 0);
        beat(1'b1, 1'b1, 1, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R7 slots zero", slots_free, 0);
        check("R7 drained", disp_count, 4);
        check("R8 still pending", carry_pending, 1);
        check("R8 still blocked", accept, 0);
        beat(1'b1, 1'b1, 2, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R7 partial slots", slots_free, 2);
        check("R7 carry gone", carry_pending, 0);
        check("R12 accept", accept, 1);
        check("R12 sum", disp_count, 4);
        beat(1'b0, 1'b0, 0, 1'b0, 1'b0, 64, 1'b1, 1'b1);
        check("R12 budget used", slots_free, 0);
    endtask

    task automatic t_ready();
        beat(1'b1, 1'b1, 3, 1'b0, 1'b0, 2, 1'b0, 1'b1);
        check("R10 rob stall", stall_rob, 1);
        check("R10 rf stall", stall_rf, 1);
        check("R9 refuse", accept, 0);
        beat(1'b0, 1'b1, 3, 1'b0, 1'b0, 3, 1'b1, 1'b0);
        check("R9 next not ready", accept, 0);
        check("R10 no stall", stall_rob + stall_rf, 0);
        check("R9 budget kept", slots_free, 4);
        beat(1'b0, 1'b1, 3, 1'b0, 1'b0, 3, 1'b1, 1'b1);
        check("R9 accept", accept, 1);
        check("R9 count", disp_count, 3);
        beat(1'b0, 1'b1, 2, 1'b0, 1'b0, 0, 1'b0, 1'b1);
        check("R10 slot fail hides stall", stall_rob + stall_rf, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cycle_start = 0; in_valid = 0; in_uops = 0; in_begin_grp = 0;
        in_end_grp = 0; rob_free = 0; rf_ready = 0; next_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_default_width();
        idle();
        idle();
        t_fill();
        t_begin();
        t_end();
        t_oversize();
        t_ready();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule